// File: doc/BRIEF.md
# Configurable PCI Base Address Register

This block is the device-side logic for one base address register in a PCI configuration space. Configuration software reaches it with 32-bit reads and writes at one fixed dword offset. Elaboration parameters decide what the register describes. It can describe an I/O port window or a memory window. The window size is a power of two. For memory windows, the decoding width type and the prefetchable attribute are also fixed by parameter.

Some bits are writable and others are hardwired. The attribute bits at the bottom of the register read back their fixed values. The address bits that fall inside the window read back as zero. Because of this, software can find the window size by writing all ones and reading the register back. It then writes the register again to place the window. The stored base drives a combinational hit output. The hit output tells the device whether an incoming address falls inside its window. Hits are gated by the matching decode-enable input.

Top module: `cfg_bar_unit`

## Requirements
- R1: Read bit 0 is read-only and shows the space kind: 1 for an I/O window, 0 for a memory window.
- R2: In I/O mode, read bit 1 and read bits 31:16 are always 0, whatever value is written.
- R3: In memory mode, read bits 2:1 return the type parameter (00 means 32-bit decoding, 10 means 64-bit decoding). Read bit 3 returns 1 when the window is prefetchable and 0 when it is not. Writes do not change these bits.
- R4: Address bits below log2(window size) read 0 and ignore writes. For example, a 4 KB, 32-bit, non-prefetchable memory window reads 0xFFFFF000 after all ones are written.
- R5: Writable base bits clear to 0 on reset. After a write, they hold the written value.
- R6: A write updates only the byte lanes whose enable is set. Enable bit n covers data bits 8n+7:8n.
- R7: Only accesses whose address bits 7:2 equal those of the offset parameter (default 0x10) reach the register. Writes to other offsets change nothing, and reads of other offsets return 0.
- R8: Read data appears in the cycle after the read request and is 0 in every other cycle. A read issued in the same cycle as a write returns the value from before the write.
- R9: The hit output is 1 when the space flag matches the mode, the matching enable input is 1, and the address masked to the writable bits equals the stored base. That is, the address lies in [base, base+size).
- R10: The hit output is 0 while the matching enable input is 0, or while the space flag does not match the mode.
- R11: In I/O mode, only the low 16 address bits take part in the comparison.
- R12: The hit output compares against the stored base. A new base affects decoding from the cycle after its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Configuration write request |
| cfg_rd | input | 1 | Configuration read request |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_be | input | 4 | Write byte-lane enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data, zero when idle |
| io_en | input | 1 | I/O decode enable |
| mem_en | input | 1 | Memory decode enable |
| req_is_io | input | 1 | Incoming access targets I/O space |
| req_addr | input | 32 | Incoming access address |
| hit | output | 1 | Incoming address falls in this window |

## Verification
A configuration write and an address decode can fall in the same cycle. A read can also coincide with that write. The bench provokes this by driving a write that moves the base together with an address inside the new window and a read of the register, all in one cycle. Before the clock edge, the hit output must reflect only the old base. After the edge, it must reflect the new base. The read that coincided with the write must return the value from before the write. The bench also checks these rules across random writes, reads and decodes on I/O, plain memory and prefetchable memory instances.

// File: rtl/cfg_bar_pkg.sv
`timescale 1ns/1ps
package cfg_bar_pkg;

  localparam int DW = 32;

  // Bits that software may write: above the window size, and below 16 in I/O mode
  function automatic logic [DW-1:0] base_mask(input bit is_io, input int size_log2);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) begin
      m[i] = (i >= size_log2) && (!is_io || (i < 16));
    end
    return m;
  endfunction

  // Fixed attribute pattern in the low bits
  function automatic logic [DW-1:0] attr_bits(input bit is_io, input logic [1:0] typ,
                                              input bit pf);
    logic [DW-1:0] a;
    a = '0;
    if (is_io) begin
      a[0] = 1'b1;
    end else begin
      a[2:1] = typ;
      a[3]   = pf;
    end
    return a;
  endfunction

endpackage

// File: rtl/cfg_bar_rstsync.sv
`timescale 1ns/1ps
module cfg_bar_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/cfg_bar_store.sv
`timescale 1ns/1ps
module cfg_bar_store #(
  parameter int          DW    = 32,
  parameter logic [DW-1:0] WMASK = '0
) (
  input  logic            clk,
  input  logic            srst_n,
  input  logic            wr_en,
  input  logic [DW/8-1:0] be,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   base_q
);
  localparam int LANES = DW / 8;

  logic [DW-1:0] lane_mask;
  logic [DW-1:0] upd;
  logic [DW-1:0] base_d;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_mask[g*8 +: 8] = {8{be[g]}};
    end
  endgenerate

  always_comb begin
    upd    = lane_mask & WMASK & {DW{wr_en}};
    base_d = (base_q & ~upd) | (wdata & upd);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    base_q <= '0;
    else if (wr_en) base_q <= base_d;
  end
endmodule

// File: rtl/cfg_bar_decode.sv
`timescale 1ns/1ps
module cfg_bar_decode #(
  parameter int            DW    = 32,
  parameter bit            IS_IO = 1'b0,
  parameter logic [DW-1:0] WMASK = '0
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] req_addr,
  input  logic          req_is_io,
  input  logic          io_en,
  input  logic          mem_en,
  output logic          hit
);
  logic space_ok;
  logic en_ok;
  logic range_ok;

  generate
    if (IS_IO) begin : g_io
      assign space_ok = req_is_io;
      assign en_ok    = io_en;
    end else begin : g_mem
      assign space_ok = !req_is_io;
      assign en_ok    = mem_en;
    end
  endgenerate

  always_comb begin
    range_ok = ((req_addr & WMASK) == (base & WMASK));
    hit      = space_ok && en_ok && range_ok;
  end
endmodule

// File: rtl/cfg_bar_unit.sv
`timescale 1ns/1ps
module cfg_bar_unit #(
  parameter logic [7:0] BAR_OFFSET = 8'h10,
  parameter bit         IS_IO      = 1'b0,
  parameter int         SIZE_LOG2  = 12,
  parameter logic [1:0] MEM_TYPE   = 2'b00,
  parameter bit         PREFETCH   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [7:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        io_en,
  input  logic        mem_en,
  input  logic        req_is_io,
  input  logic [31:0] req_addr,
  output logic        hit
);
  localparam int          DW    = cfg_bar_pkg::DW;
  localparam logic [DW-1:0] WMASK = cfg_bar_pkg::base_mask(IS_IO, SIZE_LOG2);
  localparam logic [DW-1:0] ATTR  = cfg_bar_pkg::attr_bits(IS_IO, MEM_TYPE, PREFETCH);

  logic          srst_n;
  logic          sel;
  logic          wr_sel;
  logic          rd_sel;
  logic [DW-1:0] base_q;
  logic [DW-1:0] rdata_d;
  logic [DW-1:0] rdata_q;
  logic          unused_lo;

  assign unused_lo = &{1'b0, cfg_addr[1:0]};

  cfg_bar_rstsync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    sel    = (cfg_addr[7:2] == BAR_OFFSET[7:2]);
    wr_sel = cfg_wr && sel;
    rd_sel = cfg_rd && sel;
  end

  cfg_bar_store #(.DW(DW), .WMASK(WMASK)) u_store (
    .clk    (clk),
    .srst_n (srst_n),
    .wr_en  (wr_sel),
    .be     (cfg_be),
    .wdata  (cfg_wdata),
    .base_q (base_q)
  );

  cfg_bar_decode #(.DW(DW), .IS_IO(IS_IO), .WMASK(WMASK)) u_dec (
    .base      (base_q),
    .req_addr  (req_addr),
    .req_is_io (req_is_io),
    .io_en     (io_en),
    .mem_en    (mem_en),
    .hit       (hit)
  );

  // Read path: registered, zero when not selected
  always_comb begin
    rdata_d = rd_sel ? ((base_q & WMASK) | ATTR) : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign cfg_rdata = rdata_q;
endmodule

// File: rtl/cfg_bar_chk.sv
`timescale 1ns/1ps
module cfg_bar_chk #(
  parameter logic [7:0] BAR_OFFSET = 8'h10,
  parameter bit         IS_IO      = 1'b0,
  parameter int         SIZE_LOG2  = 12,
  parameter logic [1:0] MEM_TYPE   = 2'b00,
  parameter bit         PREFETCH   = 1'b0
) (
  input logic        clk,
  input logic        srst_n,
  input logic        cfg_rd,
  input logic [7:0]  cfg_addr,
  input logic [31:0] cfg_rdata,
  input logic        io_en,
  input logic        mem_en,
  input logic        req_is_io,
  input logic        hit
);
  localparam int          LOWB  = IS_IO ? 2 : 4;
  localparam logic [31:0] LOWZ  = ((32'h1 << SIZE_LOG2) - 1) & ~((32'h1 << LOWB) - 1);

  logic rd_here;
  assign rd_here = cfg_rd && (cfg_addr[7:2] == BAR_OFFSET[7:2]);

  assert_space_bit_R1: assert property (@(posedge clk) disable iff (!srst_n)
    $past(rd_here) |-> (cfg_rdata[0] == IS_IO));

  assert_io_zero_R2: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(rd_here) && IS_IO) |-> (cfg_rdata[31:16] == 16'h0 && !cfg_rdata[1]));

  assert_mem_attr_R3: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(rd_here) && !IS_IO) |-> (cfg_rdata[3:1] == {PREFETCH, MEM_TYPE}));

  assert_size_zero_R4: assert property (@(posedge clk) disable iff (!srst_n)
    $past(rd_here) |-> ((cfg_rdata & LOWZ) == 32'h0));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!srst_n)
    !$past(rd_here) |-> (cfg_rdata == 32'h0));

  assert_hit_gate_R10: assert property (@(posedge clk) disable iff (!srst_n)
    hit |-> ((req_is_io == IS_IO) && (IS_IO ? io_en : mem_en)));
endmodule

bind cfg_bar_unit cfg_bar_chk #(
  .BAR_OFFSET (BAR_OFFSET),
  .IS_IO      (IS_IO),
  .SIZE_LOG2  (SIZE_LOG2),
  .MEM_TYPE   (MEM_TYPE),
  .PREFETCH   (PREFETCH)
) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .cfg_rd    (cfg_rd),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .io_en     (io_en),
  .mem_en    (mem_en),
  .req_is_io (req_is_io),
  .hit       (hit)
);

// File: tb/cfg_bar_unit_test.sv
`timescale 1ns/1ps
module cfg_bar_unit_test;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr, cfg_rd;
  logic [7:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        io_en, mem_en, req_is_io;
  logic [31:0] req_addr;
  logic [31:0] rd_m, rd_i, rd_p;
  logic        hit_m, hit_i, hit_p;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Expected masks and attributes, derived from the requirements
  localparam logic [31:0] WM_M = 32'hFFFFF000;  // 4 KB memory
  localparam logic [31:0] WM_I = 32'h0000FFE0;  // 32-byte I/O
  localparam logic [31:0] WM_P = 32'hFFFFFFF0;  // 16-byte memory
  localparam logic [31:0] AT_M = 32'h0;
  localparam logic [31:0] AT_I = 32'h1;
  localparam logic [31:0] AT_P = 32'hC;         // prefetch, 64-bit type

  logic [31:0] eb_m, eb_i, eb_p;

  cfg_bar_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_m), .io_en(io_en),
    .mem_en(mem_en), .req_is_io(req_is_io), .req_addr(req_addr), .hit(hit_m));

  cfg_bar_unit #(.IS_IO(1'b1), .SIZE_LOG2(5)) uut_io (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_i), .io_en(io_en),
    .mem_en(mem_en), .req_is_io(req_is_io), .req_addr(req_addr), .hit(hit_i));

  cfg_bar_unit #(.SIZE_LOG2(4), .MEM_TYPE(2'b10), .PREFETCH(1'b1)) uut_pf (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_p), .io_en(io_en),
    .mem_en(mem_en), .req_is_io(req_is_io), .req_addr(req_addr), .hit(hit_p));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] next_base(input logic [31:0] old, input logic [31:0] d,
                                            input logic [3:0] be, input logic [31:0] wm);
    logic [31:0] lm;
    for (int i = 0; i < 4; i++) lm[i*8 +: 8] = {8{be[i]}};
    return (old & ~(lm & wm)) | (d & lm & wm);
  endfunction

  function automatic logic exp_hit(input logic [31:0] b, input logic [31:0] wm,
                                   input bit is_io, input logic [31:0] a,
                                   input logic rio, input logic ie, input logic me);
    return (rio == is_io) && (is_io ? ie : me) && ((a & wm) == b);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (a[7:2] == 6'h04) begin
      eb_m = next_base(eb_m, d, be, WM_M);
      eb_i = next_base(eb_i, d, be, WM_I);
      eb_p = next_base(eb_p, d, be, WM_P);
    end
  endtask

  task automatic do_read(input string req, input logic [7:0] a);
    bit here;
    here = (a[7:2] == 6'h04);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    check({req, " mem"}, rd_m, here ? (eb_m | AT_M) : 32'h0);
    check({req, " io"},  rd_i, here ? (eb_i | AT_I) : 32'h0);
    check({req, " pf"},  rd_p, here ? (eb_p | AT_P) : 32'h0);
    @(negedge clk);
    check({req, " idle R8"}, rd_m | rd_i | rd_p, 32'h0);
  endtask

  task automatic do_dec(input string req, input logic [31:0] a, input logic rio,
                        input logic ie, input logic me);
    @(negedge clk);
    req_addr = a; req_is_io = rio; io_en = ie; mem_en = me;
    #1;
    check({req, " mem"}, {31'h0, hit_m}, {31'h0, exp_hit(eb_m, WM_M, 1'b0, a, rio, ie, me)});
    check({req, " io"},  {31'h0, hit_i}, {31'h0, exp_hit(eb_i, WM_I, 1'b1, a, rio, ie, me)});
    check({req, " pf"},  {31'h0, hit_p}, {31'h0, exp_hit(eb_p, WM_P, 1'b0, a, rio, ie, me)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    cfg_wr = 0; cfg_rd = 0; cfg_addr = 0; cfg_be = 0; cfg_wdata = 0;
    io_en = 0; mem_en = 0; req_is_io = 0; req_addr = 0;
    eb_m = 0; eb_i = 0; eb_p = 0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R5 reset, R1/R3 attributes
    do_read("R5 R1 R3 reset", 8'h10);
    // R4 sizing with all ones; mem must read FFFFF000
    do_write(8'h10, 4'hF, 32'hFFFFFFFF);
    do_read("R4 R2 size mask", 8'h10);
    check("R4 mem 4KB", eb_m | AT_M, 32'hFFFFF000);
    // R7 other offsets
    do_write(8'h14, 4'hF, 32'h0);
    do_read("R7 other offset write", 8'h10);
    do_read("R7 other offset read", 8'h18);
    // R6 byte lanes
    do_write(8'h10, 4'b0101, 32'h12345678);
    do_read("R6 byte lanes", 8'h10);
    // R5 assign a base
    do_write(8'h10, 4'hF, 32'hA0000000);
    do_read("R5 assign", 8'h10);
    do_write(8'h10, 4'b0011, 32'h00001240);
    do_read("R5 R6 low lanes", 8'h10);
    // R9 R10 R11 decode corners
    do_dec("R9 mem in range", eb_m + 32'h10, 1'b0, 1'b0, 1'b1);
    do_dec("R9 mem top edge", eb_m | 32'hFFF, 1'b0, 1'b0, 1'b1);
    do_dec("R9 mem past end", eb_m + 32'h1000, 1'b0, 1'b0, 1'b1);
    do_dec("R10 mem disabled", eb_m, 1'b0, 1'b1, 1'b0);
    do_dec("R10 space mismatch", eb_m, 1'b1, 1'b1, 1'b1);
    do_dec("R11 io upper ignored", 32'hDEAD0000 | eb_i | 32'h1F, 1'b1, 1'b1, 1'b0);
    do_dec("R10 io disabled", eb_i, 1'b1, 1'b0, 1'b1);

    // R12 R8 write, read and decode in one cycle
    begin
      logic [31:0] old_m;
      old_m = eb_m;
      @(negedge clk);
      cfg_wr = 1'b1; cfg_rd = 1'b1; cfg_addr = 8'h10; cfg_be = 4'hF;
      cfg_wdata = 32'h55555000;
      req_addr = 32'h55555123; req_is_io = 1'b0; mem_en = 1'b1; io_en = 1'b0;
      #1;
      check("R12 old base before edge", {31'h0, hit_m},
            {31'h0, exp_hit(old_m, WM_M, 1'b0, 32'h55555123, 1'b0, 1'b0, 1'b1)});
      @(negedge clk);
      cfg_wr = 1'b0; cfg_rd = 1'b0;
      check("R8 read returns pre-write", rd_m, old_m | AT_M);
      eb_m = next_base(eb_m, 32'h55555000, 4'hF, WM_M);
      eb_i = next_base(eb_i, 32'h55555000, 4'hF, WM_I);
      eb_p = next_base(eb_p, 32'h55555000, 4'hF, WM_P);
      #1;
      check("R12 new base after edge", {31'h0, hit_m}, 32'h1);
    end

    // Random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      logic [31:0] d;
      logic [7:0]  a;
      op = $urandom % 4;
      a  = ($urandom % 2) ? 8'h10 : 8'(($urandom % 64) << 2);
      d  = ($urandom % 5 == 0) ? 32'hFFFFFFFF : $urandom;
      case (op)
        0: do_write(a, 4'($urandom), d);
        1: do_read("R5 R6 R7 random read", a);
        2: do_dec("R9 R10 random near", (($urandom % 2) ? eb_m : eb_p) + ($urandom % 32'h2000),
                  1'($urandom), 1'($urandom), 1'($urandom));
        default: do_dec("R11 random io", {16'($urandom), eb_i[15:0] + 16'($urandom % 64)},
                        1'($urandom), 1'($urandom), 1'($urandom));
      endcase
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule